// File: doc/BRIEF.md
# Zero-Address Stack Execution Core

This block runs a stream of stack instructions against a small hardware operand stack and a private word-addressed data memory. Arithmetic never names an operand. A binary operation takes the two entries at the top of the stack, removes both, and leaves its result on top. Only the memory-transfer instructions carry an address. One of them loads a memory word onto the stack. The other writes the top entry back to memory and removes it. A literal instruction places a zero-extended constant from the instruction's field on the stack, so the memory can be seeded through the instruction port alone.

Expressions are issued in postfix order and need no parentheses. For example, the sum of the products X·Y and W·U is issued as load X, load Y, multiply, load W, load U, multiply, add, store Z. Each accepted instruction completes in the clock cycle in which it is accepted. The host watches the top-of-stack value, the depth count and two one-cycle error pulses.

Top module: `stk_exec_core`

## Requirements
- R1: While `rst` is high, `in_ready` is low. In the first cycle after reset, `depth` is 0, `tos` is 0 and both error flags are low. After that, `in_ready` stays high.
- R2: The instruction word is 16 bits: an opcode in bits 15:12 and an address or literal field in bits 11:0. Opcode 3 (literal) pushes the field, zero-extended to 16 bits. One cycle later `tos` shows that value and `depth` has risen by one.
- R3: The stack holds 8 entries. A push (opcode 1 or 3) at depth 8 is dropped: `depth` and `tos` stay unchanged and `ovf_err` is high for the single following cycle.
- R4: Opcode 1 (load) pushes the data-memory word at the 12-bit address in the field.
- R5: Opcode 2 (store) writes `tos` to the data-memory word at the address in the field and removes the top entry. A later load from that address returns the stored word.
- R6: Opcode 4 (add) replaces the two topmost entries with their sum modulo 2^16. Depth drops by one.
- R7: Opcode 5 (subtract) replaces the two topmost entries with the second-from-top entry minus the top entry, modulo 2^16.
- R8: Opcode 6 (multiply) replaces the two topmost entries with the low 16 bits of their product.
- R9: A binary opcode (4, 5 or 6) issued with fewer than two entries, or a store issued on an empty stack, leaves the stack and the data memory unchanged. `unf_err` is then high for the single following cycle.
- R10: An instruction presented with `in_valid` low, or carrying any opcode other than 1 to 6, changes neither the stack nor the memory and raises no flag.
- R11: The postfix sequence for X·Y + W·U, followed by a store to Z, leaves the correct 16-bit result in Z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word is valid |
| in_ready | output | 1 | Core accepts an instruction this cycle |
| in_instr | input | 16 | Opcode in bits 15:12, address or literal field in bits 11:0 |
| tos | output | 16 | Current top-of-stack value, 0 when the stack is empty |
| depth | output | 4 | Number of occupied stack entries, 0 to 8 |
| ovf_err | output | 1 | One-cycle pulse after a push was dropped on a full stack |
| unf_err | output | 1 | One-cycle pulse after an operation found too few entries |

## Verification
The bench fills the stack to its limit and pushes once more. A core that let that push through would corrupt the depth count or wrap `tos`. It issues a binary operation with zero entries and with one entry, and a store on an empty stack. A core that got these wrong would drop the depth below zero, or would write a stale word into memory that a later load exposes. Subtraction is issued with operands whose order matters, so a swapped operand order shows up as a negated result. Multiplication is issued on operands whose product overflows 16 bits, which checks that only the low half is kept. Random instruction mixes with idle cycles and unused opcodes run against an independent stack-and-memory model.

// File: rtl/stk_exec_pkg.sv
package stk_exec_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP   = 4'd0,
    OP_LOAD  = 4'd1,
    OP_STORE = 4'd2,
    OP_LIT   = 4'd3,
    OP_ADD   = 4'd4,
    OP_SUB   = 4'd5,
    OP_MUL   = 4'd6
  } op_e;

  function automatic logic op_is_binary(input op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL);
  endfunction

  function automatic logic op_is_push(input op_e op);
    return (op == OP_LOAD) || (op == OP_LIT);
  endfunction

endpackage

// File: rtl/stk_datamem.sv
module stk_datamem #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data
);
  localparam int WORDS = 1 << ADDR_W;

  logic [WORD_W-1:0] cells [WORDS];

  // Combinational read so a load completes in the cycle it is accepted.
  assign rd_data = cells[addr];

  always_ff @(posedge clk) begin
    if (wr_en) cells[addr] <= wr_data;
  end
endmodule

// File: rtl/stk_opstack.sv
module stk_opstack #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_en,
  input  logic [WORD_W-1:0] push_data,
  input  logic              pop_en,
  input  logic              fold_en,
  input  logic [WORD_W-1:0] fold_data,
  output logic [WORD_W-1:0] top,
  output logic [WORD_W-1:0] below,
  output logic [CNT_W-1:0]  count
);
  logic [WORD_W-1:0] slot [DEPTH];
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (push_en)          cnt <= cnt + 1'b1;
    else if (pop_en | fold_en) cnt <= cnt - 1'b1;
  end

  // A push writes slot[cnt]; a fold writes the result over slot[cnt-2].
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_en && cnt == CNT_W'(i))
        slot[i] <= push_data;
      else if (fold_en && cnt == CNT_W'(i + 2))
        slot[i] <= fold_data;
    end
  end

  always_comb begin
    top   = '0;
    below = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt == CNT_W'(i + 1)) top = slot[i];
      if (i + 2 <= DEPTH && cnt == CNT_W'(i + 2)) below = slot[i];
    end
  end

  assign count = cnt;
endmodule

// File: rtl/stk_alu.sv
module stk_alu
  import stk_exec_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  op_e               op,
  input  logic [WORD_W-1:0] lhs,
  input  logic [WORD_W-1:0] rhs,
  output logic [WORD_W-1:0] res
);
  localparam int PROD_W = 2 * WORD_W;

  function automatic logic [WORD_W-1:0] f_add(input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [WORD_W-1:0] f_sub(input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b);
    return a - b;
  endfunction

  function automatic logic [WORD_W-1:0] f_mul(input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b);
    logic [PROD_W-1:0] p;
    p = PROD_W'(a) * PROD_W'(b);
    return p[WORD_W-1:0];
  endfunction

  always_comb begin
    case (op)
      OP_ADD:  res = f_add(lhs, rhs);
      OP_SUB:  res = f_sub(lhs, rhs);
      OP_MUL:  res = f_mul(lhs, rhs);
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/stk_exec_core.sv
module stk_exec_core
  import stk_exec_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 12,
  parameter int STK_DEPTH = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             in_valid,
  output logic                             in_ready,
  input  logic [OPC_W+ADDR_W-1:0]          in_instr,
  output logic [WORD_W-1:0]                tos,
  output logic [$clog2(STK_DEPTH+1)-1:0]   depth,
  output logic                             ovf_err,
  output logic                             unf_err
);
  localparam int INSTR_W = OPC_W + ADDR_W;
  localparam int CNT_W   = $clog2(STK_DEPTH + 1);

  op_e               op;
  logic [ADDR_W-1:0] field;
  logic              accept;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] top_w, below_w, mem_rd, alu_res, push_val;

  // Named events, also observed by the bound checker.
  logic ev_push, ev_ovf, ev_bin, ev_store, ev_unf;
  logic want_push, want_bin, want_store, is_full, has_two, is_empty;

  assign in_ready = ~rst;
  assign accept   = in_valid & in_ready;
  assign op       = op_e'(in_instr[INSTR_W-1 -: OPC_W]);
  assign field    = in_instr[ADDR_W-1:0];

  assign want_push  = accept & op_is_push(op);
  assign want_bin   = accept & op_is_binary(op);
  assign want_store = accept & (op == OP_STORE);

  assign is_full  = (cnt == CNT_W'(STK_DEPTH));
  assign has_two  = (cnt >= CNT_W'(2));
  assign is_empty = (cnt == '0);

  assign ev_push  = want_push  & ~is_full;
  assign ev_ovf   = want_push  &  is_full;
  assign ev_bin   = want_bin   &  has_two;
  assign ev_store = want_store & ~is_empty;
  assign ev_unf   = (want_bin & ~has_two) | (want_store & is_empty);

  assign push_val = (op == OP_LIT) ? WORD_W'(field) : mem_rd;

  stk_datamem #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_mem (
    .clk     (clk),
    .wr_en   (ev_store),
    .addr    (field),
    .wr_data (top_w),
    .rd_data (mem_rd)
  );

  stk_alu #(.WORD_W(WORD_W)) u_alu (
    .op  (op),
    .lhs (below_w),
    .rhs (top_w),
    .res (alu_res)
  );

  stk_opstack #(.WORD_W(WORD_W), .DEPTH(STK_DEPTH), .CNT_W(CNT_W)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push_en   (ev_push),
    .push_data (push_val),
    .pop_en    (ev_store),
    .fold_en   (ev_bin),
    .fold_data (alu_res),
    .top       (top_w),
    .below     (below_w),
    .count     (cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_err <= 1'b0;
      unf_err <= 1'b0;
    end else begin
      ovf_err <= ev_ovf;
      unf_err <= ev_unf;
    end
  end

  assign tos   = top_w;
  assign depth = cnt;
endmodule

// File: rtl/stk_exec_chk.sv
module stk_exec_chk #(
  parameter int STK_DEPTH = 8,
  parameter int CNT_W     = $clog2(STK_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic [CNT_W-1:0] depth,
  input logic             ovf_err,
  input logic             unf_err,
  input logic             ev_push,
  input logic             ev_bin,
  input logic             ev_store
);
  p_not_ready_in_reset_r1: assert property (@(posedge clk) rst |-> !in_ready);

  p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (rst) in_ready);

  p_depth_bound_r3: assert property (@(posedge clk) disable iff (rst)
    depth <= CNT_W'(STK_DEPTH));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    ovf_err |-> ($stable(depth) && depth == CNT_W'(STK_DEPTH)));

  p_push_grows_r2: assert property (@(posedge clk) disable iff (rst)
    ev_push |=> depth == $past(depth) + 1'b1);

  p_store_shrinks_r5: assert property (@(posedge clk) disable iff (rst)
    ev_store |=> depth == $past(depth) - 1'b1);

  p_fold_shrinks_r6: assert property (@(posedge clk) disable iff (rst)
    ev_bin |=> depth == $past(depth) - 1'b1);

  p_underflow_holds_r9: assert property (@(posedge clk) disable iff (rst)
    unf_err |-> ($stable(depth) && depth < CNT_W'(2)));

  p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(ovf_err && unf_err));
endmodule

bind stk_exec_core stk_exec_chk #(.STK_DEPTH(STK_DEPTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_ready (in_ready),
  .depth    (depth),
  .ovf_err  (ovf_err),
  .unf_err  (unf_err),
  .ev_push  (ev_push),
  .ev_bin   (ev_bin),
  .ev_store (ev_store)
);

// File: tb/tb_stk_exec_core.sv
`timescale 1ns/1ps
module tb_stk_exec_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_instr = '0;
  logic [15:0] tos;
  logic [3:0]  depth;
  logic        ovf_err, unf_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Bench model of the stack and memory
  logic [15:0] ms [8];
  int          md = 0;
  logic [15:0] mm [4096];

  always #4 clk = ~clk;

  stk_exec_core dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .tos(tos), .depth(depth),
    .ovf_err(ovf_err), .unf_err(unf_err)
  );

  function automatic logic [15:0] ref_op(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
    logic [15:0] acc;
    acc = '0;
    case (op)
      4'd4: acc = a + b;
      4'd5: acc = a + (~b) + 16'd1;
      4'd6: for (int k = 0; k < 16; k++) if (b[k]) acc = acc + (a << k);
      default: acc = '0;
    endcase
    return acc;
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3: return "R2";
      4'd4: return "R6";
      4'd5: return "R7";
      4'd6: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, compare at the next falling edge.
  task automatic issue(input bit v, input logic [3:0] op, input logic [11:0] f, input string req);
    bit e_ovf = 0;
    bit e_unf = 0;
    if (v) begin
      case (op)
        4'd1, 4'd3: if (md == 8) e_ovf = 1;
                    else begin ms[md] = (op == 4'd3) ? {4'h0, f} : mm[f]; md++; end
        4'd2: if (md == 0) e_unf = 1;
              else begin mm[f] = ms[md-1]; md--; end
        4'd4, 4'd5, 4'd6: if (md < 2) e_unf = 1;
              else begin ms[md-2] = ref_op(op, ms[md-2], ms[md-1]); md--; end
        default: ;
      endcase
    end
    in_valid = v;
    in_instr = {op, f};
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_instr = '0;
    chk(req, "tos", tos, (md == 0) ? 16'h0 : ms[md-1]);
    chk(req, "depth", {12'h0, depth}, 16'(md));
    chk(req, "ovf_err", {15'h0, ovf_err}, {15'h0, e_ovf});
    chk(req, "unf_err", {15'h0, unf_err}, {15'h0, e_unf});
  endtask

  task automatic drain();
    while (md > 0) issue(1, 4'd2, 12'hF00, "R5");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "ready in reset", {15'h0, in_ready}, 16'h0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1", "ready", {15'h0, in_ready}, 16'h1);
    chk("R1", "tos", tos, 16'h0);
    chk("R1", "depth", {12'h0, depth}, 16'h0);
    chk("R1", "flags", {14'h0, ovf_err, unf_err}, 16'h0);

    // R9: underflow on an empty stack and with a single entry
    issue(1, 4'd4, 12'h0, "R9");
    issue(1, 4'd3, 12'h055, "R2");
    issue(1, 4'd2, 12'h020, "R5");
    issue(1, 4'd2, 12'h020, "R9");
    issue(1, 4'd3, 12'h0AB, "R2");
    issue(1, 4'd6, 12'h0, "R9");
    issue(1, 4'd1, 12'h020, "R4");
    chk("R9", "memory kept", tos, 16'h0055);
    drain();

    // R7: operand order, R8: product truncation
    issue(1, 4'd3, 12'd2, "R2");
    issue(1, 4'd3, 12'd9, "R2");
    issue(1, 4'd5, 12'h0, "R7");
    chk("R7", "2-9", tos, 16'hFFF9);
    issue(1, 4'd3, 12'hFFF, "R2");
    issue(1, 4'd3, 12'hFFF, "R2");
    issue(1, 4'd6, 12'h0, "R8");
    chk("R8", "low product", tos, 16'hE001);
    issue(1, 4'd4, 12'h0, "R6");
    drain();

    // R3: fill to the limit, then push once more of each kind
    for (int k = 0; k < 8; k++) issue(1, 4'd3, 12'(k + 1), "R2");
    issue(1, 4'd3, 12'h777, "R3");
    issue(1, 4'd1, 12'h020, "R3");
    chk("R3", "tos kept", tos, 16'h0008);
    // R10: idle and unused opcodes leave everything alone
    issue(0, 4'd2, 12'h020, "R10");
    issue(1, 4'd0, 12'h020, "R10");
    issue(1, 4'd15, 12'h020, "R10");
    issue(1, 4'd7, 12'h020, "R10");
    drain();
    issue(1, 4'd1, 12'h020, "R10");
    issue(1, 4'd2, 12'h021, "R10");

    // R11: X*Y + W*U -> Z
    issue(1, 4'd3, 12'd3, "R11"); issue(1, 4'd2, 12'h010, "R11");
    issue(1, 4'd3, 12'd5, "R11"); issue(1, 4'd2, 12'h011, "R11");
    issue(1, 4'd3, 12'd7, "R11"); issue(1, 4'd2, 12'h012, "R11");
    issue(1, 4'd3, 12'd2, "R11"); issue(1, 4'd2, 12'h013, "R11");
    issue(1, 4'd1, 12'h010, "R11");
    issue(1, 4'd1, 12'h011, "R11");
    issue(1, 4'd6, 12'h0, "R11");
    issue(1, 4'd1, 12'h012, "R11");
    issue(1, 4'd1, 12'h013, "R11");
    issue(1, 4'd6, 12'h0, "R11");
    issue(1, 4'd4, 12'h0, "R11");
    issue(1, 4'd2, 12'h014, "R11");
    issue(1, 4'd1, 12'h014, "R11");
    chk("R11", "Z", tos, 16'd29);
    drain();

    // Seed an address pool for random loads and stores
    for (int k = 0; k < 8; k++) begin
      issue(1, 4'd3, 12'($urandom), "R2");
      issue(1, 4'd2, 12'(12'h100 + k), "R5");
    end

    for (int n = 0; n < 600; n++) begin
      int r;
      logic [3:0] op;
      logic [11:0] f;
      r = int'($urandom % 16);
      if (r < 4)       op = 4'd3;
      else if (r < 6)  op = 4'd1;
      else if (r < 8)  op = 4'd2;
      else if (r < 10) op = 4'd4;
      else if (r < 12) op = 4'd5;
      else if (r < 14) op = 4'd6;
      else             op = 4'($urandom);
      f = ((op == 4'd1) || (op == 4'd2)) ? 12'(12'h100 + ($urandom % 8)) : 12'($urandom);
      if ($urandom % 10 == 0) issue(0, op, f, "R10");
      else                    issue(1, op, f, tag_of(op));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule